// File: doc/BRIEF.md
# Tuner Control Register Slave (I2C)

This block is the serial control port of a tuner controller. It watches an I2C bus on a fast system clock and acts as a slave on that bus. It holds twelve 8-bit control registers and presents every bit of them in parallel to the rest of the chip. A host programs the registers with write transfers. Each write transfer names a starting sub-address once, and every data byte after it lands at the next location. A read transfer returns a single status byte that is built from a lock flag and a 3-bit sub-band code, which come in from the tuning logic.

The device address is `1100_0xy`, where `xy` comes from a two-pin strap. Up to four of these slaves can therefore share one bus.

The controller is one state machine with these states:

- `ST_IDLE`: no transfer is in progress.
- `ST_DEVADDR`: shifting in the address byte.
- `ST_DEVACK`: driving the address acknowledge.
- `ST_SUBADDR`: shifting in the sub-address.
- `ST_SUBACK`: driving the acknowledge for the sub-address.
- `ST_WDATA`: shifting in a data byte.
- `ST_WACK`: driving the acknowledge for a data byte.
- `ST_RDATA`: shifting out the status byte.
- `ST_RACK`: sampling the master's acknowledge.
- `ST_RWAIT`: released after a master NACK.
- `ST_IGNORE`: the address did not match.

The transitions are as follows:

- STOP moves any state to `ST_IDLE`.
- START moves any state to `ST_DEVADDR`.
- On the SCL falling edge that follows the eighth bit, `ST_DEVADDR` moves to `ST_DEVACK` if the address matches and to `ST_IGNORE` if it does not.
- On the next SCL falling edge, `ST_DEVACK` moves to `ST_SUBADDR` when the R/W bit is 0 and to `ST_RDATA` when it is 1.
- `ST_SUBADDR` moves to `ST_SUBACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WACK` alternate for as long as the master keeps sending bytes.
- After eight bits, `ST_RDATA` moves to `ST_RACK`.
- `ST_RACK` moves back to `ST_RDATA` if the master acknowledged, and to `ST_RWAIT` if it did not.

Top module: `tuner_i2c_ctrl`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `1100_0` followed by `addr_sel_i[1:0]`. After any other address it leaves SDA released for the remaining bytes, until the next START or STOP.
- R2: START (SDA falls while SCL is high) restarts address reception from any state. STOP (SDA rises while SCL is high) returns the slave to idle. A data byte that is cut short by START or STOP writes nothing.
- R3: Bits are taken from SDA on SCL rising edges, and the first bit is the MSB.
- R4: After each byte it accepts in a write transfer (address, sub-address, data), the slave pulls SDA low for the ninth clock. It changes its SDA drive only while SCL is low.
- R5: In a write transfer, the byte after the address is the sub-address. Each later byte is stored at the current sub-address, and the sub-address then advances by one.
- R6: A data byte aimed at a sub-address above 0x0B is acknowledged and discarded. The pointer never advances beyond 0x0B, so further bytes overwrite register 0x0B.
- R7: A read (R/W = 1) returns a status byte, MSB first: bit 7 is the lock flag, bits 6:4 are the sub-band code, and bits 3:0 are 0. The status byte is sent again for every byte the master acknowledges.
- R8: After the master NACKs a read byte, the slave keeps SDA released until STOP or START.
- R9: After reset, all registers are 0 and SDA is released.
- R10: Register k is visible on `ctrl_regs_o[8k+7:8k]` for k = 0 to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel_i | input | 2 | Strap giving the two low address bits |
| pll_lock_i | input | 1 | Lock flag reported in the status byte |
| sub_band_i | input | 3 | Sub-band code reported in the status byte |
| ctrl_regs_o | output | 96 | All twelve control registers, register k at bits 8k+7:8k |

## Verification
Several properties are checked on every cycle:

- SDA drive changes only while SCL is low.
- STOP always leads back to idle.
- The write pointer never leaves the register range once it is inside it.
- No register changes without a write strobe, and that strobe never carries an out-of-range index.
- SDA stays released after a NACK.

Only the bench's transfers can show the rest: the address match against each strap value, MSB-first assembly of the bytes, the exact byte that lands in each register under auto-increment and saturation, the status-byte layout, and the discarding of bytes that a START or STOP cuts short.

// File: rtl/tnr_i2c_pkg.sv
package tnr_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_SUBADDR,
        ST_SUBACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_RWAIT,
        ST_IGNORE
    } i2c_state_e;

    // Fixed upper part of the 7-bit device address
    localparam logic [4:0] DEV_ID_HI = 5'b11000;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/tnr_i2c_sync.sv
module tnr_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] the previous one
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_prev;
    logic            sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_prev = sda_pipe[STAGES];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/tnr_i2c_regbank.sv
module tnr_i2c_regbank #(
    parameter int NUM_REGS = 12,
    parameter int REG_W    = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                q <= wr_data;
            end
        end
        assign regs_o[g*REG_W +: REG_W] = q;
    end

    // R6: the controller never strobes an index outside the bank
    a_r6_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr <= LAST_IDX));

    // R5: register contents move only on a write strobe
    a_r5_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

endmodule

// File: rtl/tnr_i2c_fsm.sv
module tnr_i2c_fsm
    import tnr_i2c_pkg::*;
#(
    parameter int NUM_REGS = 12,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    input  logic              pll_lock,
    input  logic [2:0]        sub_band,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [BYTE_W-1:0] LAST_PTR = BYTE_W'(NUM_REGS - 1);
    localparam logic [3:0]        BITS     = 4'd8;

    i2c_state_e        state_q, state_d;
    logic [3:0]        cnt_q, cnt_d;
    logic [BYTE_W-1:0] shift_q, shift_d;
    logic [BYTE_W-1:0] ptr_q, ptr_d;
    logic [BYTE_W-1:0] status_byte;
    logic              addr_match;
    logic              byte_done;

    assign status_byte = {pll_lock, sub_band, 4'b0000};
    assign addr_match  = (shift_q[7:1] == {DEV_ID_HI, addr_sel});
    assign byte_done   = scl_fall && (cnt_q == BITS);

    // Next-state and datapath logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shift_d = shift_q;
        ptr_d   = ptr_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEVADDR;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_DEVADDR: begin
                    if (scl_rise && cnt_q < BITS) begin
                        shift_d = {shift_q[6:0], sda_s};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        state_d = addr_match ? ST_DEVACK : ST_IGNORE;
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (shift_q[0]) begin
                            state_d = ST_RDATA;
                            shift_d = status_byte;
                        end else begin
                            state_d = ST_SUBADDR;
                        end
                    end
                end
                ST_SUBADDR: begin
                    if (scl_rise && cnt_q < BITS) begin
                        shift_d = {shift_q[6:0], sda_s};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        ptr_d   = shift_q;
                        state_d = ST_SUBACK;
                    end
                end
                ST_SUBACK, ST_WACK: begin
                    if (scl_fall) begin
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise && cnt_q < BITS) begin
                        shift_d = {shift_q[6:0], sda_s};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        if (ptr_q < LAST_PTR) begin
                            ptr_d = ptr_q + 8'd1;
                        end
                        state_d = ST_WACK;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && cnt_q < BITS) begin
                        cnt_d = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        state_d = ST_RACK;
                    end else if (scl_fall && cnt_q != 4'd0) begin
                        shift_d = {shift_q[6:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        shift_d[0] = sda_s;
                    end else if (scl_fall) begin
                        if (!shift_q[0]) begin
                            state_d = ST_RDATA;
                            shift_d = status_byte;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_RWAIT;
                        end
                    end
                end
                ST_RWAIT, ST_IGNORE: begin
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
            ptr_q   <= ptr_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_DEVACK, ST_SUBACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:                      sda_oe = ~shift_q[7];
            default:                       sda_oe = 1'b0;
        endcase
        wr_en   = (state_q == ST_WDATA) && byte_done && !stop_det && !start_det
                  && (ptr_q <= LAST_PTR);
        wr_addr = ptr_q[ADDR_W-1:0];
        wr_data = shift_q;
    end

    // R4: SDA drive is taken on only while SCL is low
    a_r4_grab_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R4: SDA drive is let go only while SCL is low
    a_r4_release_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);

    // R2: a STOP always ends in idle
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

    // R6: once inside the bank, the pointer stays inside until a new sub-address
    a_r6_ptr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SUBADDR && ptr_q <= LAST_PTR) |=> (ptr_q <= LAST_PTR));

    // R8: released for as long as the slave waits after a NACK
    a_r8_quiet_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RWAIT) |-> !sda_oe);

endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
    import tnr_i2c_pkg::*;
#(
    parameter int NUM_REGS    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [1:0]                 addr_sel_i,
    input  logic                       pll_lock_i,
    input  logic [2:0]                 sub_band_i,
    output logic [NUM_REGS*BYTE_W-1:0] ctrl_regs_o
);

    localparam int ADDR_W = $clog2(NUM_REGS);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;

    tnr_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tnr_i2c_fsm #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel_i),
        .pll_lock  (pll_lock_i),
        .sub_band  (sub_band_i),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    tnr_i2c_regbank #(.NUM_REGS(NUM_REGS), .REG_W(BYTE_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (ctrl_regs_o)
    );

endmodule

// File: tb/tuner_i2c_ctrl_bench.sv
module tuner_i2c_ctrl_bench;

    localparam int NREG = 12;
    localparam int Q    = 5;   // quarter SCL period in system clocks

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_oe;
    logic [1:0]      strap = 2'b00;
    logic            lock = 1'b0;
    logic [2:0]      sband = 3'b000;
    logic [NREG*8-1:0] regs;
    logic            sda_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] exp_regs [NREG];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    tuner_i2c_ctrl u_tuner_i2c_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .addr_sel_i  (strap),
        .pll_lock_i  (lock),
        .sub_band_i  (sband),
        .ctrl_regs_o (regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_of(input logic lk, input logic [2:0] sb);
        return {lk, sb, 4'b0000};
    endfunction

    function automatic logic [6:0] dev_of(input logic [1:0] s);
        return {5'b11000, s};
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~master_ack);
    endtask

    // Full write transfer; returns the number of acknowledged bytes
    task automatic do_write(input logic [6:0] dev, input logic [7:0] sub, input int n,
                            output int acks);
        logic a;
        acks = 0;
        bus_start();
        put_byte({dev, 1'b0}, a); acks += int'(a);
        put_byte(sub, a);         acks += int'(a);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], a); acks += int'(a);
        end
        bus_stop();
    endtask

    task automatic model_write(input logic [7:0] sub, input int n);
        int p = int'(sub);
        for (int i = 0; i < n; i++) begin
            if (p <= NREG - 1) exp_regs[p] = wbuf[i];
            if (p < NREG - 1) p++;
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NREG; k++)
            chk(req, {24'd0, regs[k*8 +: 8]}, {24'd0, exp_regs[k]});
    endtask

    // Read transfer of n bytes, master NACKs the last one
    task automatic do_read(input logic [6:0] dev, input int n, output logic acked,
                           input bit do_stop);
        logic a;
        bus_start();
        put_byte({dev, 1'b1}, a);
        acked = a;
        for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
        if (do_stop) bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int acks;
        logic a;
        logic [7:0] v;
        void'($urandom(32'd2024));
        for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;

        wq(4);
        // R9: reset state
        chk("R9 regs at reset", {31'd0, |regs}, 32'd0);
        chk("R9 sda released at reset", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        wq(4);

        // R3 R5 R10: MSB-first bytes written from sub-address 0
        wbuf[0] = 8'h81; wbuf[1] = 8'h18; wbuf[2] = 8'hC3;
        do_write(dev_of(strap), 8'h00, 3, acks);
        model_write(8'h00, 3);
        chk("R4 every write byte acked", acks, 5);
        chk("R3 first byte msb first", {24'd0, regs[7:0]}, 32'h81);
        check_regs("R5 R10 auto increment from 0");

        // R6: saturation at the last register
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC4; wbuf[3] = 8'hD8;
        do_write(dev_of(strap), 8'h0A, 4, acks);
        model_write(8'h0A, 4);
        chk("R6 acks past end", acks, 6);
        chk("R6 last register holds final byte", {24'd0, regs[95:88]}, 32'hD8);
        check_regs("R6 saturation");

        // R6: out-of-range sub-address acknowledged but discarded
        wbuf[0] = 8'h55; wbuf[1] = 8'h66;
        do_write(dev_of(strap), 8'h20, 2, acks);
        chk("R6 out of range acked", acks, 4);
        check_regs("R6 out of range discarded");

        // R1: wrong address gets no ack at all
        wbuf[0] = 8'h77;
        do_write(dev_of(strap ^ 2'b01), 8'h02, 1, acks);
        chk("R1 foreign address not acked", acks, 0);
        check_regs("R1 foreign address no write");
        do_write(7'b1000011, 8'h02, 1, acks);
        chk("R1 wrong upper bits not acked", acks, 0);

        // R1: each strap value selects its own address
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            wq(4);
            wbuf[0] = 8'(8'h10 + s);
            do_write(dev_of(2'(s)), 8'(s + 4), 1, acks);
            model_write(8'(s + 4), 1);
            chk("R1 strap address acked", acks, 3);
        end
        check_regs("R1 strap writes");

        // R7 R8: status reads
        lock = 1'b1; sband = 3'b101;
        do_read(dev_of(strap), 2, a, 1'b0);
        chk("R7 read address acked", {31'd0, a}, 32'd1);
        chk("R7 status byte 0", {24'd0, rbuf[0]}, {24'd0, status_of(1'b1, 3'b101)});
        chk("R7 status byte 1", {24'd0, rbuf[1]}, {24'd0, status_of(1'b1, 3'b101)});
        get_byte(1'b0, v);
        chk("R8 released after nack", {24'd0, v}, 32'hFF);
        chk("R8 sda_oe low after nack", {31'd0, sda_oe}, 32'd0);
        bus_stop();
        lock = 1'b0; sband = 3'b011;
        do_read(dev_of(strap), 1, a, 1'b1);
        chk("R7 unlocked status", {24'd0, rbuf[0]}, {24'd0, status_of(1'b0, 3'b011)});
        do_read(dev_of(strap ^ 2'b10), 1, a, 1'b1);
        chk("R1 foreign read not acked", {31'd0, a}, 32'd0);
        chk("R1 foreign read floats", {24'd0, rbuf[0]}, 32'hFF);

        // R2: STOP inside a data byte writes nothing
        bus_start();
        put_byte({dev_of(strap), 1'b0}, a);
        put_byte(8'h03, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        check_regs("R2 stop mid byte");

        // R2: repeated START inside a data byte restarts address phase
        bus_start();
        put_byte({dev_of(strap), 1'b0}, a);
        put_byte(8'h05, a);
        for (int i = 0; i < 3; i++) put_bit(1'b0);
        bus_start();
        put_byte({dev_of(strap), 1'b0}, a);
        chk("R2 address after restart acked", {31'd0, a}, 32'd1);
        put_byte(8'h06, a);
        put_byte(8'h5A, a);
        bus_stop();
        exp_regs[6] = 8'h5A;
        check_regs("R2 restart");

        // Random transfers checked against the model
        for (int t = 0; t < 24; t++) begin
            logic [7:0] sub;
            int n;
            if ($urandom_range(0, 3) == 0) begin
                lock  = 1'($urandom_range(0, 1));
                sband = 3'($urandom_range(0, 7));
                do_read(dev_of(strap), 2, a, 1'b1);
                chk("R7 random status", {24'd0, rbuf[1]},
                    {24'd0, status_of(lock, sband)});
            end else begin
                sub = 8'($urandom_range(0, 15));
                n   = $urandom_range(1, 6);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom_range(0, 255));
                do_write(dev_of(strap), sub, n, acks);
                model_write(sub, n);
                chk("R4 random acks", acks, n + 2);
                check_regs("R5 R6 R10 random write");
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule